// File: doc/BRIEF.md
# Start-of-Frame Tick Tracker

This block raises the start-of-frame status event for a USB controller that can act as host or as device. It counts a free-running microsecond strobe. In host role it emits a periodic time-base tick every microframe, but only while the PHY clock runs and the port is not suspended. In device role, each received SOF token raises the event and restarts the timer. If no token arrives well beyond the expected frame time, the block raises a substitute event so software still sees the frame boundary.

The expected period depends on speed. At full speed it is one frame, which is eight microframes. At high speed it is one microframe. A token counts as missing once 1.5 times the nominal period has passed without one. After a substitute event, further substitutes follow at the nominal period until a real token resynchronizes the timer. The block leaves reset in device role at full speed, so events arrive on the full-speed frame rhythm while the link is connecting.

The output `sof_evt` is a one-cycle set pulse for a status bit. It rises in the cycle after the input that caused it.

Top module: `sof_tick_tracker`

## Requirements
- R1: During reset and in the first cycle after it, `sof_evt` is 0. The timer holds zero, and the remembered role is device.
- R2: In host role, with `phy_clk_on`=1 and `port_suspended`=0, `sof_evt` pulses for one cycle after every UFRAME_US-th `us_tick`. The pulse appears in the cycle after the strobe that completes the count.
- R3: In host role, while `phy_clk_on`=0 or `port_suspended`=1, no event is raised and the timer is held at zero. The first tick after the clock resumes comes UFRAME_US strobes later.
- R4: In device role, a `sof_rx` pulse raises `sof_evt` in the next cycle and restarts the timer at zero.
- R5: In device role, if floor(1.5 × period) strobes pass with no `sof_rx`, a substitute event is raised. The period is UFRAME_US×FS_MULT at full speed (`high_speed`=0) and UFRAME_US at high speed (`high_speed`=1).
- R6: After a substitute event, the next substitute comes one nominal period of strobes later if no token arrives.
- R7: A `sof_rx` that arrives after a substitute event, but before the next `us_tick`, raises no event. It still restarts the timer at zero.
- R8: `high_speed` selects the lateness limit of the device-role timer at every strobe.
- R9: In a cycle where `host_role` differs from its value in the previous cycle, no event is raised, `sof_rx` is ignored, and the timer restarts at zero.
- R10: Out of reset, with no tokens arriving in device role at full speed, the first substitute event follows floor(1.5 × UFRAME_US × FS_MULT) strobes.
- R11: When `sof_rx` and `us_tick` coincide in device role, the token takes priority: one event is raised and the timer restarts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_role | input | 1 | 1 = host role, 0 = device role |
| high_speed | input | 1 | 1 = high speed, 0 = full speed (device role) |
| phy_clk_on | input | 1 | PHY clock present |
| port_suspended | input | 1 | Port is suspended |
| sof_rx | input | 1 | One-cycle pulse per received SOF token |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| sof_evt | output | 1 | One-cycle set pulse for the SOF status bit |

## Verification
The bench builds the block with UFRAME_US=8 and FS_MULT=4. This gives a full-speed period of 32 strobes, a full-speed lateness limit of 48 strobes and a high-speed limit of 12 strobes. At these values, repeated substitute events, the restart offset after a substitute, suppression and the speed switch all occur within a few hundred cycles. A long run with random tokens, strobes, role flips and suspends then exercises their interleavings against a behavioural model.

// File: rtl/sof_tick_tracker.sv
module sof_tick_tracker #(
  parameter int UFRAME_US = 125,
  parameter int FS_MULT   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_role,
  input  logic high_speed,
  input  logic phy_clk_on,
  input  logic port_suspended,
  input  logic sof_rx,
  input  logic us_tick,
  output logic sof_evt
);
  localparam int FS_PERIOD = UFRAME_US * FS_MULT;
  localparam int FS_LATE   = (FS_PERIOD * 3) / 2;
  localparam int HS_LATE   = (UFRAME_US * 3) / 2;
  localparam int FS_RST    = FS_LATE - FS_PERIOD;
  localparam int HS_RST    = HS_LATE - UFRAME_US;
  localparam int CNT_W     = $clog2(FS_LATE + 1);

  logic [CNT_W-1:0] elapsed;
  logic             role_q;
  logic             recent_sub;

  wire              running = phy_clk_on && !port_suspended;
  wire [CNT_W-1:0]  next_el = elapsed + 1'b1;
  wire [CNT_W-1:0]  limit   = host_role  ? CNT_W'(UFRAME_US) :
                              high_speed ? CNT_W'(HS_LATE) : CNT_W'(FS_LATE);
  wire [CNT_W-1:0]  restart = high_speed ? CNT_W'(HS_RST) : CNT_W'(FS_RST);
  wire              due     = us_tick && (next_el >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed    <= '0;
      role_q     <= 1'b0;
      recent_sub <= 1'b0;
      sof_evt    <= 1'b0;
    end else begin
      role_q  <= host_role;
      sof_evt <= 1'b0;
      if (host_role != role_q) begin
        elapsed    <= '0;
        recent_sub <= 1'b0;
      end else if (host_role) begin
        recent_sub <= 1'b0;
        if (!running) begin
          elapsed <= '0;
        end else if (due) begin
          elapsed <= '0;
          sof_evt <= 1'b1;
        end else if (us_tick) begin
          elapsed <= next_el;
        end
      end else if (sof_rx) begin
        elapsed    <= '0;
        sof_evt    <= !recent_sub;
        recent_sub <= 1'b0;
      end else if (due) begin
        elapsed    <= restart;
        sof_evt    <= 1'b1;
        recent_sub <= 1'b1;
      end else if (us_tick) begin
        elapsed    <= next_el;
        recent_sub <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sof_tick_tracker_sva.sv
module sof_tick_tracker_sva #(
  parameter int UFRAME_US = 125,
  parameter int FS_MULT   = 8,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_role,
  input logic             phy_clk_on,
  input logic             port_suspended,
  input logic             sof_rx,
  input logic             us_tick,
  input logic             sof_evt,
  input logic             role_q,
  input logic [CNT_W-1:0] elapsed
);
  localparam int FS_LATE = (UFRAME_US * FS_MULT * 3) / 2;

  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q && host_role && !(phy_clk_on && !port_suspended)) |=> (!sof_evt && elapsed == '0)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_rx && !us_tick) |=> !sof_evt); // R2
  AST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_q && !host_role && sof_rx) |=> (elapsed == '0)); // R4
  AST_ROLE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q != host_role) |=> (!sof_evt && elapsed == '0)); // R9
  AST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed < CNT_W'(FS_LATE)); // R5
endmodule

bind sof_tick_tracker sof_tick_tracker_sva #(
  .UFRAME_US(UFRAME_US), .FS_MULT(FS_MULT), .CNT_W(CNT_W)
) i_sva (
  .clk(clk), .rst_n(rst_n), .host_role(host_role), .phy_clk_on(phy_clk_on),
  .port_suspended(port_suspended), .sof_rx(sof_rx), .us_tick(us_tick),
  .sof_evt(sof_evt), .role_q(role_q), .elapsed(elapsed)
);

// File: tb/test_sof_tick_tracker.sv
module test_sof_tick_tracker;
  localparam int UF  = 8;
  localparam int FSM = 4;
  localparam int FSP = UF * FSM;
  localparam int FSL = FSP * 3 / 2;
  localparam int HSL = UF * 3 / 2;

  logic clk = 0, rst_n = 0;
  logic host_role = 0, high_speed = 0, phy_clk_on = 1, port_suspended = 0;
  logic sof_rx = 0, us_tick = 0;
  logic sof_evt;

  int checks = 0, errors = 0, pulses = 0, cycles = 0;
  string tag = "R1";

  int m_el = 0, m_role = 0, m_rec = 0, m_evt = 0;

  sof_tick_tracker #(.UFRAME_US(UF), .FS_MULT(FSM)) i_sof_tick_tracker (
    .clk(clk), .rst_n(rst_n), .host_role(host_role), .high_speed(high_speed),
    .phy_clk_on(phy_clk_on), .port_suspended(port_suspended),
    .sof_rx(sof_rx), .us_tick(us_tick), .sof_evt(sof_evt));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    int lim, nx;
    if (!rst_n) begin
      m_el = 0; m_role = 0; m_rec = 0; m_evt = 0;
    end else begin
      m_evt = 0;
      nx = m_el + 1;
      lim = host_role ? UF : (high_speed ? HSL : FSL);
      if (int'(host_role) != m_role) begin
        m_el = 0; m_rec = 0;
      end else if (host_role) begin
        m_rec = 0;
        if (!phy_clk_on || port_suspended) m_el = 0;
        else if (us_tick) begin
          if (nx >= lim) begin m_el = 0; m_evt = 1; end
          else m_el = nx;
        end
      end else if (sof_rx) begin
        m_evt = (m_rec == 0) ? 1 : 0; m_el = 0; m_rec = 0;
      end else if (us_tick) begin
        if (nx >= lim) begin
          m_el = lim - (high_speed ? UF : FSP); m_evt = 1; m_rec = 1;
        end else begin m_el = nx; m_rec = 0; end
      end
      m_role = host_role;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(sof_evt) != m_evt) begin
      errors++;
      $display("FAIL %s cycle %0d sof_evt actual %0d expected %0d", tag, cycles, sof_evt, m_evt);
    end
    if (sof_evt) pulses++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1;
      @(negedge clk); us_tick = 0;
    end
    @(negedge clk);
  endtask

  task automatic sof(input logic with_tick);
    @(negedge clk); sof_rx = 1; us_tick = with_tick;
    @(negedge clk); sof_rx = 0; us_tick = 0;
    @(negedge clk);
  endtask

  task automatic expect_pulses(input int base, input int delta, input string r);
    checks++;
    if (pulses - base != delta) begin
      errors++;
      $display("FAIL %s pulse count actual %0d expected %0d", r, pulses - base, delta);
    end
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    checks++;
    if (sof_evt !== 1'b0) begin
      errors++; $display("FAIL R1 sof_evt in reset actual %0b expected 0", sof_evt);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (sof_evt !== 1'b0) begin
      errors++; $display("FAIL R1 sof_evt after reset actual %0b expected 0", sof_evt);
    end

    tag = "R10"; b = pulses; strobe(FSL - 1); expect_pulses(b, 0, "R10");
    b = pulses; strobe(1); expect_pulses(b, 1, "R10");
    tag = "R6";  b = pulses; strobe(FSP - 1); expect_pulses(b, 0, "R6");
    b = pulses; strobe(1); expect_pulses(b, 1, "R6");
    tag = "R7";  b = pulses; sof(0); expect_pulses(b, 0, "R7");
    tag = "R4";  strobe(10); b = pulses; sof(0); expect_pulses(b, 1, "R4");
    tag = "R5";  b = pulses; strobe(FSL - 1); expect_pulses(b, 0, "R5");
    b = pulses; strobe(1); expect_pulses(b, 1, "R5");
    tag = "R11"; strobe(1); b = pulses; sof(1); expect_pulses(b, 1, "R11");
    b = pulses; strobe(FSL - 1); expect_pulses(b, 0, "R11");
    tag = "R8";  sof(0); high_speed = 1;
    b = pulses; strobe(HSL - 1); expect_pulses(b, 0, "R8");
    b = pulses; strobe(1); expect_pulses(b, 1, "R8");
    b = pulses; strobe(UF - 1); expect_pulses(b, 0, "R6");
    b = pulses; strobe(1); expect_pulses(b, 1, "R6");

    tag = "R9"; b = pulses;
    @(negedge clk); host_role = 1; sof_rx = 1;
    @(negedge clk); sof_rx = 0;
    @(negedge clk); expect_pulses(b, 0, "R9");
    tag = "R2"; b = pulses; strobe(UF - 1); expect_pulses(b, 0, "R2");
    b = pulses; strobe(1 + 2 * UF); expect_pulses(b, 3, "R2");
    tag = "R3"; strobe(3); port_suspended = 1;
    b = pulses; strobe(2 * UF); expect_pulses(b, 0, "R3");
    port_suspended = 0; b = pulses; strobe(UF - 1); expect_pulses(b, 0, "R3");
    b = pulses; strobe(1); expect_pulses(b, 1, "R3");
    phy_clk_on = 0; b = pulses; strobe(2 * UF); expect_pulses(b, 0, "R3");
    phy_clk_on = 1;

    tag = "random";
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      us_tick = ($urandom_range(0, 2) == 0);
      sof_rx = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 600) == 0) host_role = ~host_role;
      if ($urandom_range(0, 300) == 0) high_speed = ~high_speed;
      if ($urandom_range(0, 400) == 0) port_suspended = ~port_suspended;
      if ($urandom_range(0, 500) == 0) phy_clk_on = ~phy_clk_on;
    end
    @(negedge clk); us_tick = 0; sof_rx = 0;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule